// File: doc/BRIEF.md
# Cascaded Four-Bit Column Data Loader

This block fills an 80-position line register for one column driver in a chain of identical drivers. It accepts four parallel data bits on each falling edge of a data strobe and writes them into the next group of four positions. An internal group counter and decoder choose that group. Loading happens only while the driver is in column mode and its active-low chain enable is asserted.

After the last group is written, the block ignores further strobes and pulls its active-low carry output low. That output is wired to the chain enable of the next driver, so a single shared data bus feeds all devices one after another. A single direction input reverses the fill direction along the line and, with it, the order of the four bits inside each group. A falling edge on the line latch strobe rearms the counter for the next line.

All strobes are sampled by the block clock, and their edges are detected inside the block. Every input is taken to be synchronous to that clock.

Top module: `col_loader_top`

## Requirements
- R1: After reset, all 80 data outputs are 0 and `carry_n_o` is 1.
- R2: A group is written only on a detected falling edge of `shift_clk_i` while `col_mode_i` is 1 and `chain_en_n_i` is 0. Falling edges seen while `chain_en_n_i` is 1 write nothing and do not advance the group counter.
- R3: With `fill_rev_i` = 0, write k (k = 0..19) stores `nib_i[j]` into `data_o[4k+j]`. Bit 0 of `data_o` is the first output position, and `nib_i` bits 0..3 are the four data lanes in lane order.
- R4: With `fill_rev_i` = 1, write k stores `nib_i[j]` into `data_o[79-4k-j]`, so the first group lands at the far end with lane 0 on the last position.
- R5: Twenty writes fill all 80 positions. Each write changes only its own four positions.
- R6: After twenty writes, further `shift_clk_i` falling edges leave `data_o` unchanged.
- R7: `carry_n_o` goes to 0 on the clock edge that performs the twentieth write, and stays 0 until rearmed.
- R8: A detected falling edge of `line_latch_i` returns the counter to the first group and `carry_n_o` to 1. Stored data is kept until it is overwritten.
- R9: While `col_mode_i` is 0, no group is written and `carry_n_o` is 1.
- R10: When `line_latch_i` and `shift_clk_i` fall in the same clock cycle, the rearm takes effect and no group is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock that samples all strobes |
| rst_n | input | 1 | Synchronous active-low reset |
| shift_clk_i | input | 1 | Data strobe; one group is written per falling edge |
| line_latch_i | input | 1 | Line strobe; its falling edge rearms the loader |
| col_mode_i | input | 1 | 1 selects column loading; 0 idles the loader |
| chain_en_n_i | input | 1 | Active-low enable from the previous device's carry |
| fill_rev_i | input | 1 | 0 fills from position 0 upward; 1 fills from position 79 downward |
| nib_i | input | 4 | Four parallel data lanes (bit 0 = lane 0) |
| data_o | output | 80 | Stored line data (bit 0 = first position) |
| carry_n_o | output | 1 | Active-low enable for the next device; 0 once the line is full |

## Verification
The hardest case to reach from the ports is the edge that writes the twentieth group, together with what follows it. Twenty qualified strobes must have passed, with no rearm and no disabled strobe miscounted, before the carry can fall. Only then can the hold after completion be observed. The stimulus fills the whole line in both directions, checking the carry after every single write. It then sends extra strobes while full, interleaves strobes sent with the enable high partway through a line, and drives a line strobe in the same cycle as a data strobe to show that the rearm wins.

// File: rtl/col_loader_pkg.sv
// Package: col_loader_pkg
// Shared sizing for the column loader. Every width and count used by the
// loader's modules is derived here from the channel count and group width.
package col_loader_pkg;
    parameter int unsigned CH_NUM  = 80;   // stored positions per line
    parameter int unsigned GRP_W   = 4;    // positions written per strobe
    parameter int unsigned GRP_NUM = CH_NUM / GRP_W;
    parameter int unsigned CNT_W   = $clog2(GRP_NUM + 1);
endpackage

// File: rtl/col_edge_det.sv
// Module: col_edge_det
// Detects falling edges on a vector of strobes sampled by clk.
// Assumes: the inputs are already synchronous to clk. The reset value of 0
// means that a strobe which is low out of reset gives no edge.
module col_edge_det #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] fall_o
);
    logic [N-1:0] prev_q;

    // Keep the last sampled value of each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sig_i;
    end

    // An edge is a high sample followed by a current low level.
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_fall
            assign fall_o[g] = prev_q[g] & ~sig_i[g];
        end
    endgenerate
endmodule

// File: rtl/col_grp_seq.sv
// Module: col_grp_seq
// Sequencer: counts the groups written in the current line, gates the write
// strobe, and drives the active-low carry to the next device.
// Assumes: edge pulses last one clk cycle. A line rearm has priority over a
// write that falls in the same cycle.
module col_grp_seq
    import col_loader_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_fall_i,
    input  logic             line_fall_i,
    input  logic             col_mode_i,
    input  logic             chain_en_n_i,
    output logic             wr_o,
    output logic [CNT_W-1:0] grp_idx_o,
    output logic             full_o,
    output logic             carry_n_o
);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(GRP_NUM - 1);
    localparam logic [CNT_W-1:0] FULL_IDX = CNT_W'(GRP_NUM);

    logic [CNT_W-1:0] cnt_q;
    logic             carry_n_q;

    assign full_o    = (cnt_q == FULL_IDX);
    assign grp_idx_o = cnt_q;

    // Qualified write: column mode, enabled, line not full, no rearm.
    always_comb begin
        wr_o = shift_fall_i && !line_fall_i && col_mode_i
               && !chain_en_n_i && !full_o;
    end

    // Group counter: rearmed by the line strobe, advanced by each write.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (line_fall_i) cnt_q <= '0;
        else if (wr_o)        cnt_q <= cnt_q + CNT_W'(1);
    end

    // Carry: falls with the last write, rises on rearm or outside column mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                     carry_n_q <= 1'b1;
        else if (line_fall_i)           carry_n_q <= 1'b1;
        else if (!col_mode_i)           carry_n_q <= 1'b1;
        else if (wr_o && cnt_q == LAST_IDX) carry_n_q <= 1'b0;
    end

    assign carry_n_o = carry_n_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_IDX); // R5
    AST_NO_ADVANCE_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (chain_en_n_i && !line_fall_i) |=> $stable(cnt_q)); // R2
    AST_CARRY_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_o && cnt_q == LAST_IDX) |=> !carry_n_q); // R7
    AST_CARRY_IDLE_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        !col_mode_i |=> carry_n_q); // R9
    AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        line_fall_i |=> (cnt_q == '0 && carry_n_q)); // R8
endmodule

// File: rtl/col_grp_bank.sv
// Module: col_grp_bank
// Storage for the line: one slot of GRP_W bits per group. A decoder maps the
// logical group index to a physical slot. In reverse fill, the slot order and
// the lane order inside the slot are both mirrored.
// Assumes: the direction input is steady during a line.
module col_grp_bank
    import col_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [CNT_W-1:0]  grp_idx_i,
    input  logic              fill_rev_i,
    input  logic [GRP_W-1:0]  nib_i,
    output logic [CH_NUM-1:0] data_o
);
    localparam logic [CNT_W-1:0] TOP_SLOT = CNT_W'(GRP_NUM - 1);

    logic [CNT_W-1:0]   slot_idx;
    logic [GRP_NUM-1:0] sel;
    logic [GRP_W-1:0]   lane_dat;
    logic [CH_NUM-1:0]  data_q;

    // Physical slot targeted by the current logical group.
    always_comb begin
        slot_idx = fill_rev_i ? (TOP_SLOT - grp_idx_i) : grp_idx_i;
    end

    // Lane order inside a slot, mirrored in reverse fill.
    genvar j;
    generate
        for (j = 0; j < GRP_W; j++) begin : g_lane
            assign lane_dat[j] = fill_rev_i ? nib_i[GRP_W-1-j] : nib_i[j];
        end
    endgenerate

    // One select line and one register slot per group.
    genvar p;
    generate
        for (p = 0; p < GRP_NUM; p++) begin : g_slot
            assign sel[p] = wr_i && (slot_idx == CNT_W'(p));

            // Slot register: loads only when its select line is set.
            always_ff @(posedge clk) begin
                if (!rst_n)      data_q[p*GRP_W +: GRP_W] <= '0;
                else if (sel[p]) data_q[p*GRP_W +: GRP_W] <= lane_dat;
            end
        end
    endgenerate

    assign data_o = data_q;

    AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(sel)); // R3
    AST_SEL_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> $countones(sel) == 1); // R5
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(data_q)); // R2
endmodule

// File: rtl/col_loader_top.sv
// Module: col_loader_top
// Column data loader for one device in a chain. It detects strobe edges,
// sequences the group writes, and stores the line.
// Assumes: all inputs are synchronous to clk, and each strobe level lasts at
// least one clk cycle.
module col_loader_top
    import col_loader_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_clk_i,
    input  logic              line_latch_i,
    input  logic              col_mode_i,
    input  logic              chain_en_n_i,
    input  logic              fill_rev_i,
    input  logic [GRP_W-1:0]  nib_i,
    output logic [CH_NUM-1:0] data_o,
    output logic              carry_n_o
);
    logic [1:0]       fall;
    logic             wr;
    logic             full;
    logic [CNT_W-1:0] grp_idx;

    col_edge_det #(.N(2)) edge_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  ({line_latch_i, shift_clk_i}),
        .fall_o (fall)
    );

    col_grp_seq seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_fall_i (fall[0]),
        .line_fall_i  (fall[1]),
        .col_mode_i   (col_mode_i),
        .chain_en_n_i (chain_en_n_i),
        .wr_o         (wr),
        .grp_idx_o    (grp_idx),
        .full_o       (full),
        .carry_n_o    (carry_n_o)
    );

    col_grp_bank bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_i       (wr),
        .grp_idx_i  (grp_idx),
        .fill_rev_i (fill_rev_i),
        .nib_i      (nib_i),
        .data_o     (data_o)
    );

    AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !fall[1]) |=> $stable(data_o)); // R6
    AST_FULL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (full && col_mode_i && !fall[1]) |-> !carry_n_o); // R7
    AST_REARM_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (fall[1] && fall[0]) |=> $stable(data_o)); // R10
endmodule

// File: tb/col_loader_top_tb_top.sv
// Scoreboard bench: the driver task updates a reference model written from
// the requirements and queues the expected outputs. A monitor pops each item
// and compares it with the design after the write edge.
module col_loader_top_tb_top;
    typedef struct {
        logic [79:0] data;
        logic        car;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        shift_clk_i = 1'b0;
    logic        line_latch_i = 1'b0;
    logic        col_mode_i = 1'b1;
    logic        chain_en_n_i = 1'b1;
    logic        fill_rev_i = 1'b0;
    logic [3:0]  nib_i = '0;
    logic [79:0] data_o;
    logic        carry_n_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done_run = 1'b0;

    exp_t        q[$];
    event        chk_ev;
    logic [79:0] m_data = '0;
    logic        m_car = 1'b1;
    int          m_cnt = 0;

    always #5 clk = ~clk;

    col_loader_top dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .shift_clk_i  (shift_clk_i),
        .line_latch_i (line_latch_i),
        .col_mode_i   (col_mode_i),
        .chain_en_n_i (chain_en_n_i),
        .fill_rev_i   (fill_rev_i),
        .nib_i        (nib_i),
        .data_o       (data_o),
        .carry_n_o    (carry_n_o)
    );

    // Monitor: pop each expected item and compare it with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_cmp++;
                if (data_o !== e.data || carry_n_o !== e.car) begin
                    n_bad++;
                    $display("FAIL %s: data=%h carry_n=%b expected data=%h carry_n=%b",
                             e.req, data_o, carry_n_o, e.data, e.car);
                end
            end
        end
    end

    task automatic push_exp(input string req);
        exp_t e;
        e.data = m_data;
        e.car  = m_car;
        e.req  = req;
        q.push_back(e);
        ->chk_ev;
    endtask

    // Driver: raise the strobes, drop them together with the data, update
    // the model, and check one negedge after the sampling posedge.
    task automatic strobe(input bit do_line, input bit do_shift,
                          input logic [3:0] v, input string req);
        @(negedge clk);
        line_latch_i = do_line;
        shift_clk_i  = do_shift;
        @(negedge clk);
        line_latch_i = 1'b0;
        shift_clk_i  = 1'b0;
        nib_i        = v;
        if (do_line) begin
            m_cnt = 0;
            m_car = 1'b1;
        end else if (!col_mode_i) begin
            m_car = 1'b1;
        end else if (do_shift && !chain_en_n_i && m_cnt < 20) begin
            for (int j = 0; j < 4; j++) begin
                if (fill_rev_i) m_data[79 - 4*m_cnt - j] = v[j];
                else            m_data[4*m_cnt + j]      = v[j];
            end
            m_cnt++;
            if (m_cnt == 20) m_car = 1'b0;
        end
        @(negedge clk);
        push_exp(req);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        push_exp("R1 reset state");

        // R2: strobes with the enable high write nothing.
        chain_en_n_i = 1'b1;
        for (int i = 0; i < 3; i++) strobe(1'b0, 1'b1, 4'hF, "R2 enable high");
        // R9: column mode off, enable low: nothing written, carry high.
        col_mode_i = 1'b0;
        chain_en_n_i = 1'b0;
        for (int i = 0; i < 2; i++) strobe(1'b0, 1'b1, 4'hA, "R9 mode off");
        col_mode_i = 1'b1;

        // R3, R5, R7: forward fill of all twenty groups.
        fill_rev_i = 1'b0;
        for (int k = 0; k < 20; k++)
            strobe(1'b0, 1'b1, 4'((k * 7 + 3) & 15),
                   (k == 19) ? "R7 carry on last write" : "R3 forward fill");
        // R6: extra strobes once full.
        for (int i = 0; i < 3; i++) strobe(1'b0, 1'b1, 4'h5, "R6 hold when full");

        // R8: rearm, then a reverse partial line over the retained data.
        strobe(1'b1, 1'b0, 4'h0, "R8 rearm carry high");
        fill_rev_i = 1'b1;
        strobe(1'b0, 1'b1, 4'b0001, "R4 reverse first group");
        strobe(1'b0, 1'b1, 4'b1100, "R4 reverse second group");
        // R2: disabled strobes partway through a line do not advance.
        chain_en_n_i = 1'b1;
        strobe(1'b0, 1'b1, 4'hF, "R2 enable high midline");
        chain_en_n_i = 1'b0;
        strobe(1'b0, 1'b1, 4'b0110, "R2 resumes at next group");
        // R10: line strobe and data strobe in the same cycle.
        strobe(1'b1, 1'b1, 4'hF, "R10 rearm wins");
        // R4, R5, R7: reverse fill of the full line.
        for (int k = 0; k < 20; k++)
            strobe(1'b0, 1'b1, 4'((k * 5 + 9) & 15),
                   (k == 19) ? "R7 carry on last reverse write" : "R4 reverse fill");
        strobe(1'b0, 1'b1, 4'h0, "R6 hold when full reverse");
        // R9: leaving column mode returns the carry high.
        col_mode_i = 1'b0;
        strobe(1'b0, 1'b0, 4'h0, "R9 carry high off mode");

        repeat (2) @(negedge clk);
        done_run = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule